// File: doc/BRIEF.md
# Bus Takeover Arbiter for Block and Table Transfers

This block decides when the two kinds of memory transfer take the bus away from the processor. The first kind is a one-shot block copy that software requests. The second kind is a table-driven transfer. It runs once at the start of a frame as an initialisation pass, and then once per display line. The arbiter does not move any data. It latches the trigger pulses, chooses which transfer runs next, and tells the channel engines what to do through single-cycle command strobes. The engines answer with a completion pulse.

Each clock of the block stands for one master clock. Taking the bus and giving it back both cost stall clocks. On entry, the arbiter waits until the 8-clock transfer phase reaches its next boundary. On exit, it pads the time it held the bus up to a whole number of processor cycles. That way the processor resumes on its own cycle grid. After the bus is handed back, an interrupt-hold output stays high for one processor cycle, so interrupt sampling happens late.

Top module: `xfer_arbiter`

## Requirements
- R1: After reset, active, stallBusy, irqHold, tableReset and all three command strobes are low.
- R2: While idle, a pending table request or a pending block request makes active go high. This happens on the second clock edge after the trigger pulse, because one edge latches the pulse and the next edge starts the takeover. Taking over clears the count of clocks held, and this holds even if no channel is enabled at that point.
- R3: The entry stall is stallBusy held for exactly 8 minus dmaPhase clocks, where dmaPhase is the phase at the decision and takes values 0..7. It comes just before the command strobe in two cases: before cmdBlock, and before cmdInit or cmdLine when blkEnabled is low. When blkEnabled is high, a table command is issued with no stall before it.
- R4: A pending table request is always serviced before a pending block request. If both are pending, the table command comes first.
- R5: When nothing is left pending, the block stalls for cycleLen minus (k mod cycleLen) clocks and then drops active. Here k is the number of clocks active was high before the exit stall. The total time active stays high is therefore a multiple of cycleLen, which must be held while active and lie in 1..15.
- R6: An initPulse always produces a one-clock tableReset on the next clock. It sets a table request in init mode (mode 0, served by cmdInit) only when tblEnabled is high. Otherwise the bus is never taken.
- R7: A linePulse sets a table request in per-line mode (mode 1, served by cmdLine) only when tblActive is high. Otherwise it has no effect.
- R8: A request is cleared when it is serviced even if its kind turns out to have no enabled channel. Such a takeover issues no command, ends through the exit stall, and is not repeated.
- R9: irqHold goes high when active falls and stays high for exactly cycleLen clocks.
- R10: At most one command strobe is high at a time. Each strobe lasts one clock and is followed by the block waiting for xferDone. stallBusy is only ever high while active is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Active-low synchronous reset |
| initPulse | input | 1 | Frame-start trigger for the table initialisation pass |
| linePulse | input | 1 | Per-line trigger for the table transfer |
| blockReq | input | 1 | Block copy request pulse |
| tblEnabled | input | 1 | Some table channel is enabled |
| tblActive | input | 1 | Some table channel is still running this frame |
| blkEnabled | input | 1 | Some block channel is enabled |
| dmaPhase | input | 3 | Current position within the 8-clock transfer phase |
| cycleLen | input | 4 | Processor cycle length in master clocks |
| xferDone | input | 1 | Engine finished the commanded transfer |
| cmdInit | output | 1 | Strobe: run the table initialisation |
| cmdLine | output | 1 | Strobe: run the per-line table transfer |
| cmdBlock | output | 1 | Strobe: run the block copy |
| tableReset | output | 1 | Strobe: reset table state at frame start |
| stallBusy | output | 1 | Entry or exit alignment stall in progress |
| active | output | 1 | Transfers own the bus |
| irqHold | output | 1 | Interrupt sampling held off |

## Verification
The hardest state to reach from the ports is a single takeover that holds both a table request and a block request, so that the arbiter must order them and apply or skip the entry stall depending on blkEnabled. The bench reaches it by pulsing linePulse and blockReq in the same clock. It also lets the engine model answer after random delays, which moves the exit point across every residue of cycleLen. Random episodes vary dmaPhase, cycleLen and the enable flags, and the monitor derives every stall length from the lengths of the active run it observes.

// File: rtl/arbc_pkg.sv
package arbc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARB,
    ST_STALL_IN,
    ST_RUN,
    ST_STALL_OUT
  } arbState_t;

  typedef enum logic [1:0] {
    XF_NONE,
    XF_INIT,
    XF_LINE,
    XF_BLOCK
  } xferKind_t;

  // strobes from control to the counter datapath
  typedef struct packed {
    logic enterActive;   // clear held-clock residue
    logic countOn;       // bus is held this clock
    logic loadEntry;     // start phase-alignment stall
    logic loadExit;      // start cycle-alignment stall
    logic leaveActive;   // bus returned this edge
  } dpStrobe_t;

endpackage

// File: rtl/arbc_pend.sv
module arbc_pend (
  input  logic clk,
  input  logic rstN,
  input  logic initPulse,
  input  logic linePulse,
  input  logic blockReq,
  input  logic tblEnabled,
  input  logic tblActive,
  input  logic clrLine,
  input  logic clrBlock,
  output logic linePend,
  output logic lineMode,
  output logic blockPend,
  output logic tableReset
);

  logic initHit;
  logic lineHit;

  assign initHit = initPulse && tblEnabled;
  assign lineHit = linePulse && tblActive;

  // a fresh trigger wins over a clear on the same edge
  always_ff @(posedge clk) begin
    if (!rstN) begin
      linePend   <= 1'b0;
      lineMode   <= 1'b0;
      blockPend  <= 1'b0;
      tableReset <= 1'b0;
    end else begin
      tableReset <= initPulse;
      if (initHit || lineHit) linePend <= 1'b1;
      else if (clrLine)       linePend <= 1'b0;
      if (lineHit)            lineMode <= 1'b1;
      else if (initHit)       lineMode <= 1'b0;
      if (blockReq)           blockPend <= 1'b1;
      else if (clrBlock)      blockPend <= 1'b0;
    end
  end

  p_line_trig_r7: assert property (@(posedge clk) disable iff (!rstN)
    lineHit |=> (linePend && lineMode));

  p_init_trig_r6: assert property (@(posedge clk) disable iff (!rstN)
    (initHit && !linePulse) |=> (linePend && !lineMode));

  p_table_reset_r6: assert property (@(posedge clk) disable iff (!rstN)
    initPulse |=> tableReset);

endmodule

// File: rtl/arbc_dp.sv
module arbc_dp
  import arbc_pkg::*;
#(
  parameter int PHASE_W = 3,
  parameter int CYC_W   = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpStrobe_t          strobe,
  input  logic [PHASE_W-1:0] dmaPhase,
  input  logic [CYC_W-1:0]   cycleLen,
  output logic               stallLast,
  output logic               irqHold
);

  localparam int BOUND = 1 << PHASE_W;
  localparam int CNT_W = (CYC_W > PHASE_W + 1) ? CYC_W : PHASE_W + 1;

  logic [CNT_W-1:0] stallCnt;
  logic [CNT_W-1:0] entryLen;
  logic [CNT_W-1:0] exitLen;
  logic [CYC_W-1:0] modCnt;
  logic [CYC_W-1:0] modNext;
  logic [CYC_W:0]   modInc;
  logic [CYC_W-1:0] holdCnt;

  // held-clock residue modulo the processor cycle, including this clock
  assign modInc  = {1'b0, modCnt} + 1'b1;
  assign modNext = (modInc >= {1'b0, cycleLen}) ? '0 : modInc[CYC_W-1:0];

  assign entryLen = CNT_W'(BOUND) - CNT_W'(dmaPhase);
  assign exitLen  = CNT_W'(cycleLen) - CNT_W'(modNext);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stallCnt <= '0;
      modCnt   <= '0;
      holdCnt  <= '0;
    end else begin
      if (strobe.loadEntry)      stallCnt <= entryLen;
      else if (strobe.loadExit)  stallCnt <= exitLen;
      else if (stallCnt != '0)   stallCnt <= stallCnt - 1'b1;

      if (strobe.enterActive)    modCnt <= '0;
      else if (strobe.countOn)   modCnt <= modNext;

      if (strobe.leaveActive)    holdCnt <= cycleLen;
      else if (holdCnt != '0)    holdCnt <= holdCnt - 1'b1;
    end
  end

  assign stallLast = (stallCnt == CNT_W'(1));
  assign irqHold   = (holdCnt != '0);

  p_entry_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadEntry |=> (stallCnt >= CNT_W'(1) && stallCnt <= CNT_W'(BOUND)));

  p_exit_range_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadExit |=> (stallCnt >= CNT_W'(1) && stallCnt <= CNT_W'(cycleLen)));

  p_exit_aligned_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.leaveActive |-> (modNext == '0));

  p_hold_start_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.leaveActive |=> irqHold);

endmodule

// File: rtl/arbc_ctrl.sv
module arbc_ctrl
  import arbc_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      linePend,
  input  logic      lineMode,
  input  logic      blockPend,
  input  logic      tblEnabled,
  input  logic      blkEnabled,
  input  logic      xferDone,
  input  logic      stallLast,
  output dpStrobe_t strobe,
  output logic      clrLine,
  output logic      clrBlock,
  output logic      cmdInit,
  output logic      cmdLine,
  output logic      cmdBlock,
  output logic      active,
  output logic      stallBusy
);

  arbState_t state, stateNx;
  xferKind_t kindReg, kindNx;
  xferKind_t issueKind;
  logic      issue;

  always_comb begin
    stateNx   = state;
    kindNx    = kindReg;
    strobe    = '0;
    clrLine   = 1'b0;
    clrBlock  = 1'b0;
    issue     = 1'b0;
    issueKind = kindReg;
    strobe.countOn = (state != ST_IDLE);
    unique case (state)
      ST_IDLE: begin
        if (linePend || blockPend) begin
          stateNx            = ST_ARB;
          strobe.enterActive = 1'b1;
        end
      end
      ST_ARB: begin
        if (linePend) begin
          clrLine = 1'b1;
          if (tblEnabled) begin
            kindNx = lineMode ? XF_LINE : XF_INIT;
            if (!blkEnabled) begin
              strobe.loadEntry = 1'b1;
              stateNx          = ST_STALL_IN;
            end else begin
              issue     = 1'b1;
              issueKind = kindNx;
              stateNx   = ST_RUN;
            end
          end
        end else if (blockPend) begin
          clrBlock = 1'b1;
          if (blkEnabled) begin
            kindNx           = XF_BLOCK;
            strobe.loadEntry = 1'b1;
            stateNx          = ST_STALL_IN;
          end
        end else begin
          strobe.loadExit = 1'b1;
          stateNx         = ST_STALL_OUT;
        end
      end
      ST_STALL_IN: begin
        if (stallLast) begin
          issue   = 1'b1;
          stateNx = ST_RUN;
        end
      end
      ST_RUN: begin
        if (xferDone) stateNx = ST_ARB;
      end
      ST_STALL_OUT: begin
        if (stallLast) begin
          strobe.leaveActive = 1'b1;
          stateNx            = ST_IDLE;
        end
      end
      default: stateNx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      kindReg  <= XF_NONE;
      cmdInit  <= 1'b0;
      cmdLine  <= 1'b0;
      cmdBlock <= 1'b0;
    end else begin
      state    <= stateNx;
      kindReg  <= kindNx;
      cmdInit  <= issue && (issueKind == XF_INIT);
      cmdLine  <= issue && (issueKind == XF_LINE);
      cmdBlock <= issue && (issueKind == XF_BLOCK);
    end
  end

  assign active    = (state != ST_IDLE);
  assign stallBusy = (state == ST_STALL_IN) || (state == ST_STALL_OUT);

  p_cmd_onehot_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cmdInit, cmdLine, cmdBlock}));

  p_cmd_single_r10: assert property (@(posedge clk) disable iff (!rstN)
    (cmdInit || cmdLine || cmdBlock) |=> !(cmdInit || cmdLine || cmdBlock));

  p_block_stalled_r3: assert property (@(posedge clk) disable iff (!rstN)
    cmdBlock |-> ($past(state) == ST_STALL_IN));

  p_table_first_r4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ARB && linePend) |-> !clrBlock);

  p_enter_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!active && (linePend || blockPend)) |=> active);

endmodule

// File: rtl/xfer_arbiter.sv
module xfer_arbiter
  import arbc_pkg::*;
#(
  parameter int PHASE_W = 3,
  parameter int CYC_W   = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               initPulse,
  input  logic               linePulse,
  input  logic               blockReq,
  input  logic               tblEnabled,
  input  logic               tblActive,
  input  logic               blkEnabled,
  input  logic [PHASE_W-1:0] dmaPhase,
  input  logic [CYC_W-1:0]   cycleLen,
  input  logic               xferDone,
  output logic               cmdInit,
  output logic               cmdLine,
  output logic               cmdBlock,
  output logic               tableReset,
  output logic               stallBusy,
  output logic               active,
  output logic               irqHold
);

  dpStrobe_t strobe;
  logic linePend, lineMode, blockPend;
  logic clrLine, clrBlock, stallLast;

  arbc_pend u_pend (
    .clk        (clk),
    .rstN       (rstN),
    .initPulse  (initPulse),
    .linePulse  (linePulse),
    .blockReq   (blockReq),
    .tblEnabled (tblEnabled),
    .tblActive  (tblActive),
    .clrLine    (clrLine),
    .clrBlock   (clrBlock),
    .linePend   (linePend),
    .lineMode   (lineMode),
    .blockPend  (blockPend),
    .tableReset (tableReset)
  );

  arbc_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .linePend   (linePend),
    .lineMode   (lineMode),
    .blockPend  (blockPend),
    .tblEnabled (tblEnabled),
    .blkEnabled (blkEnabled),
    .xferDone   (xferDone),
    .stallLast  (stallLast),
    .strobe     (strobe),
    .clrLine    (clrLine),
    .clrBlock   (clrBlock),
    .cmdInit    (cmdInit),
    .cmdLine    (cmdLine),
    .cmdBlock   (cmdBlock),
    .active     (active),
    .stallBusy  (stallBusy)
  );

  arbc_dp #(.PHASE_W(PHASE_W), .CYC_W(CYC_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .dmaPhase  (dmaPhase),
    .cycleLen  (cycleLen),
    .stallLast (stallLast),
    .irqHold   (irqHold)
  );

  p_busy_active_r10: assert property (@(posedge clk) disable iff (!rstN)
    stallBusy |-> active);

  p_hold_after_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(active) |-> irqHold);

endmodule

// File: tb/sim_xfer_arbiter.sv
`timescale 1ns/1ps
module sim_xfer_arbiter;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic initPulse = 1'b0, linePulse = 1'b0, blockReq = 1'b0;
  logic tblEnabled = 1'b0, tblActive = 1'b0, blkEnabled = 1'b0;
  logic [2:0] dmaPhase = 3'd0;
  logic [3:0] cycleLen = 4'd6;
  logic xferDone = 1'b0;
  logic cmdInit, cmdLine, cmdBlock, tableReset, stallBusy, active, irqHold;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  // monitor state
  bit prevBusy = 0, prevActive = 0, prevHold = 0;
  int busyRun = 0, activeRun = 0, holdRun = 0;
  int epCount = 0, epN = 0, tblCmdIdx = -1, blkCmdIdx = -1;
  int epKinds[0:7];
  bit monOn = 0;

  always #2.5 clk = ~clk;

  xfer_arbiter u0 (
    .clk(clk), .rstN(rstN), .initPulse(initPulse), .linePulse(linePulse),
    .blockReq(blockReq), .tblEnabled(tblEnabled), .tblActive(tblActive),
    .blkEnabled(blkEnabled), .dmaPhase(dmaPhase), .cycleLen(cycleLen),
    .xferDone(xferDone), .cmdInit(cmdInit), .cmdLine(cmdLine),
    .cmdBlock(cmdBlock), .tableReset(tableReset), .stallBusy(stallBusy),
    .active(active), .irqHold(irqHold)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int entryLenExp(input int ph);
    return 8 - ph;
  endfunction

  function automatic int exitLenExp(input int k, input int c);
    return c - (k % c);
  endfunction

  // output monitor, samples away from the active edge
  always @(negedge clk) begin
    if (monOn) begin
      if (stallBusy && !active) chk(0, "R10 busy outside active", 1, 0);
      if (int'(cmdInit) + int'(cmdLine) + int'(cmdBlock) > 1)
        chk(0, "R10 strobes not onehot", 2, 1);
      if (active && !prevActive) begin
        epN = 0; tblCmdIdx = -1; blkCmdIdx = -1;
      end
      if (cmdBlock) begin
        chk(blkEnabled, "R3 block cmd needs channel", int'(blkEnabled), 1);
        chk(prevBusy && busyRun == entryLenExp(int'(dmaPhase)),
            "R3 entry stall before block", prevBusy ? busyRun : 0, entryLenExp(int'(dmaPhase)));
        if (blkCmdIdx < 0) blkCmdIdx = epN;
      end
      if (cmdInit || cmdLine) begin
        if (!blkEnabled)
          chk(prevBusy && busyRun == entryLenExp(int'(dmaPhase)),
              "R3 entry stall before table", prevBusy ? busyRun : 0, entryLenExp(int'(dmaPhase)));
        else
          chk(!prevBusy, "R3 no stall with block channel", int'(prevBusy), 0);
        if (tblCmdIdx < 0) tblCmdIdx = epN;
      end
      if ((cmdInit || cmdLine || cmdBlock) && epN < 8) begin
        epKinds[epN] = cmdInit ? 1 : (cmdLine ? 2 : 3);
        epN++;
      end
      if (!active && prevActive) begin
        epCount++;
        chk(prevBusy && busyRun == exitLenExp(activeRun - busyRun, int'(cycleLen)),
            "R5 exit stall length", busyRun, exitLenExp(activeRun - busyRun, int'(cycleLen)));
        chk(activeRun % int'(cycleLen) == 0, "R5 active span aligned",
            activeRun % int'(cycleLen), 0);
      end
      if (!irqHold && prevHold)
        chk(holdRun == int'(cycleLen), "R9 hold length", holdRun, int'(cycleLen));
      if (irqHold && !prevHold)
        chk(!active && prevActive || !active, "R9 hold starts at release", int'(active), 0);
    end
    busyRun   = stallBusy ? busyRun + 1 : 0;
    activeRun = active ? activeRun + 1 : 0;
    holdRun   = irqHold ? holdRun + 1 : 0;
    prevBusy  = stallBusy;
    prevActive = active;
    prevHold  = irqHold;
  end

  // engine model: answers each command after a random delay
  initial begin
    forever begin
      @(negedge clk);
      if (cmdInit || cmdLine || cmdBlock) begin
        int d;
        d = $urandom_range(1, 8);
        repeat (d) @(posedge clk);
        #1 xferDone = 1'b1;
        @(posedge clk);
        #1 xferDone = 1'b0;
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic waitQuiet();
    int q = 0;
    for (int i = 0; i < 2000 && q < 3; i++) begin
      tick();
      q = (!active && !irqHold) ? q + 1 : 0;
    end
  endtask

  task automatic pulse(input bit ini, input bit lin, input bit blk);
    initPulse = ini; linePulse = lin; blockReq = blk;
    tick();
    initPulse = 0; linePulse = 0; blockReq = 0;
  endtask

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int e0;
    void'($urandom(32'd4242));
    repeat (3) tick();
    #1.5;
    chk(!active && !stallBusy && !irqHold && !tableReset, "R1 reset quiet",
        int'(active) + int'(stallBusy) + int'(irqHold) + int'(tableReset), 0);
    chk(!cmdInit && !cmdLine && !cmdBlock, "R1 reset commands low",
        int'(cmdInit) + int'(cmdLine) + int'(cmdBlock), 0);
    @(posedge clk); #1 rstN = 1'b1;
    monOn = 1;
    tick();

    // R6: init with no table channel: reset strobe only
    tblEnabled = 0; e0 = epCount;
    pulse(1, 0, 0);
    #1.5 chk(tableReset, "R6 tableReset after init", int'(tableReset), 1);
    tick(); #1.5 chk(!tableReset, "R6 tableReset one clock", int'(tableReset), 0);
    repeat (20) tick();
    chk(epCount == e0 && !active, "R6 gated init takes no bus", epCount - e0, 0);

    // R7: line with nothing active is ignored
    tblEnabled = 1; tblActive = 0;
    pulse(0, 1, 0);
    repeat (20) tick();
    chk(epCount == e0 && !active, "R7 idle line trigger ignored", epCount - e0, 0);

    // R6: init pass, stall before it since no block channel
    cycleLen = 6; dmaPhase = 3; blkEnabled = 0;
    pulse(1, 0, 0);
    waitQuiet();
    chk(epCount == e0 + 1 && epN == 1 && epKinds[0] == 1, "R6 init command issued",
        epKinds[0], 1);

    // R7 and R3: per-line with block channel enabled, no entry stall
    tblActive = 1; blkEnabled = 1; dmaPhase = 5; cycleLen = 8;
    pulse(0, 1, 0);
    waitQuiet();
    chk(epN == 1 && epKinds[0] == 2, "R7 line command issued", epKinds[0], 2);

    // R4: both pending at once: table first
    cycleLen = 12; dmaPhase = 0;
    pulse(0, 1, 1);
    waitQuiet();
    chk(epN == 2 && tblCmdIdx == 0 && blkCmdIdx == 1, "R4 table before block",
        tblCmdIdx, 0);

    // R2 and R8: block request without channel
    blkEnabled = 0; cycleLen = 5; e0 = epCount;
    blockReq = 1; tick(); blockReq = 0;
    #1.5 chk(!active, "R2 active not yet after latch", int'(active), 0);
    tick(); #1.5 chk(active, "R2 active two edges after pulse", int'(active), 1);
    waitQuiet();
    repeat (30) tick();
    chk(epCount == e0 + 1 && epN == 0, "R8 empty request served once",
        epCount - e0, 1);

    // random episodes
    for (int n = 0; n < 300; n++) begin
      int cl;
      cl = $urandom_range(1, 15);
      cycleLen   = 4'(cl);
      dmaPhase   = 3'($urandom_range(0, 7));
      tblEnabled = 1'($urandom_range(0, 1));
      tblActive  = 1'($urandom_range(0, 1));
      blkEnabled = 1'($urandom_range(0, 1));
      pulse(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
      waitQuiet();
    end

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule